// File: doc/BRIEF.md
# Serial Equalizer Control Receiver

This block receives control frames for a four-band stereo parametric equalizer over a three-wire serial link. The three wires are an enable, a serial clock and a data line. The block oversamples all three with its own system clock. While the enable is high it shifts in one data bit on each rising edge of the serial clock. When the enable drops, it checks the frame: the frame must hold exactly 28 bits and must carry the expected device address. Only then is the frame decoded and applied to a register bank.

The bank keeps, for each of the four bands on each of the two channels, three codes: a centre-frequency index, a gain code and a Q index. It also keeps a shelving flag for the low band of each channel and one global flag that doubles the frequency. The registered codes are the outputs of the block and set the switches of the analogue filter network.

A frame carries 8 address bits and then 20 data bits. Bits arrive least significant first, and the address comes before the data. The data-bit numbers used below count from the first data bit, which is D0.

Top module: `eq_serial_ctrl`

## Requirements
- R1: Bits shift in only on rising serial-clock edges seen while the enable is high. No output changes until the enable falls. An accepted frame reaches the outputs SYNC_STAGES+1 system-clock cycles after the enable pin falls.
- R2: A frame is accepted only if the enable falls after exactly 28 serial-clock rising edges. A frame with fewer or more edges changes no register. Raising the enable restarts the count.
- R3: A frame is accepted only if its 8 address bits equal the DEV_ADDR parameter. A frame with any other address changes no register.
- R4: D7 selects the left channel and D8 selects the right channel. Setting both bits updates both channels from one frame. Setting neither updates no band.
- R5: {D6,D5,D4} selects the band. The codes are:
  - 001: low, peaking, which also clears that channel's shelving flag.
  - 110: low, shelving, which sets that channel's shelving flag.
  - 010: low-mid.
  - 011: high-mid.
  - 101: high.
  - 111: selects no band.
- R6: D12..D9 is the frequency index. Codes 0 to 10 are written to the selected band. Codes 11 to 15 leave the stored index unchanged, but the other fields of the frame still apply.
- R7: D16..D13 is the gain code. Code c means 2c-12 dB, so code 6 is 0 dB. Codes 0 to 12 are written. Codes 13 to 15 leave the stored gain unchanged, but the other fields still apply.
- R8: D2..D0 is the Q index. All 8 values are written to the selected band. Index 0 is the widest response and index 7 the narrowest.
- R9: D3 is the doubling flag, and every accepted frame copies it to the output. When D4 and D5 are both zero, the frame updates only the doubling flag, whatever its other bits hold.
- R10: After reset, every band of both channels holds gain code 6, frequency index 0 and Q index 0. Both shelving flags and the doubling flag are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling and for the register bank |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Serial enable. Frame bits are taken while it is high, and the frame is applied when it falls |
| sclk_i | input | 1 | Serial clock. Data is taken on its rising edge |
| sdat_i | input | 1 | Serial data, least significant bit first |
| dbl_o | output | 1 | Global frequency-doubling flag |
| shelf_l_o | output | 1 | Left low band is in shelving mode |
| shelf_r_o | output | 1 | Right low band is in shelving mode |
| freq_l_o | output | 16 | Left frequency indices. Band b sits at bits [4b+3:4b], with b=0 the low band |
| freq_r_o | output | 16 | Right frequency indices, with the same layout |
| gain_l_o | output | 16 | Left gain codes, 4 bits per band |
| gain_r_o | output | 16 | Right gain codes, 4 bits per band |
| q_l_o | output | 12 | Left Q indices, 3 bits per band |
| q_r_o | output | 12 | Right Q indices, 3 bits per band |

## Verification
An accepted frame is due at the outputs exactly SYNC_STAGES+1 system cycles after the bench drives the enable low. With the default setting that is 3 cycles. The bench model stores the frame as a pending update with a countdown of that length. It applies the update in the cycle the countdown reaches zero and compares every output on the falling edge of each cycle, so a result that is early or late fails. Each serial-clock phase is held for three system cycles, so data is stable well before the synchronized rising edge that captures it.

// File: rtl/eq_ctrl_pkg.sv
package eq_ctrl_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 20;
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam int NUM_CH    = 2;
  localparam int NUM_BANDS = 4;
  localparam int FREQ_W    = 4;
  localparam int GAIN_W    = 4;
  localparam int Q_W       = 3;
  localparam int BAND_W    = 3;
  localparam int BIDX_W    = $clog2(NUM_BANDS);
  localparam int FREQ_MAX  = 10;
  localparam int GAIN_MAX  = 12;
  localparam int GAIN_ZERO = 6;

  // data-word field positions (decoded by the neighbour module)
  localparam int POS_Q     = 0;
  localparam int POS_DBL   = POS_Q + Q_W;
  localparam int POS_BAND  = POS_DBL + 1;
  localparam int POS_CH    = POS_BAND + BAND_W;
  localparam int POS_FREQ  = POS_CH + NUM_CH;
  localparam int POS_GAIN  = POS_FREQ + FREQ_W;
  localparam int DATA_USED = POS_GAIN + GAIN_W;

  typedef struct packed {
    logic              hit;
    logic [BIDX_W-1:0] idx;
    logic              shelf_wr;
    logic              shelf_val;
  } band_sel_t;

  typedef struct packed {
    logic [NUM_CH-1:0] ch_mask;
    band_sel_t         band;
    logic              freq_en;
    logic [FREQ_W-1:0] freq;
    logic              gain_en;
    logic [GAIN_W-1:0] gain;
    logic [Q_W-1:0]    q;
    logic              dbl;
  } eq_cmd_t;

  function automatic logic freq_ok(input logic [FREQ_W-1:0] code);
    return code <= FREQ_W'(FREQ_MAX);
  endfunction

  function automatic logic gain_ok(input logic [GAIN_W-1:0] code);
    return code <= GAIN_W'(GAIN_MAX);
  endfunction

  function automatic band_sel_t band_lookup(input logic [BAND_W-1:0] code);
    band_sel_t r;
    r = '0;
    case (code)
      3'b001: begin r.hit = 1'b1; r.idx = 2'd0; r.shelf_wr = 1'b1; r.shelf_val = 1'b0; end
      3'b110: begin r.hit = 1'b1; r.idx = 2'd0; r.shelf_wr = 1'b1; r.shelf_val = 1'b1; end
      3'b010: begin r.hit = 1'b1; r.idx = 2'd1; end
      3'b011: begin r.hit = 1'b1; r.idx = 2'd2; end
      3'b101: begin r.hit = 1'b1; r.idx = 2'd3; end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/eq_pin_sync.sv
module eq_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/eq_frame_rx.sv
module eq_frame_rx
  import eq_ctrl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'hA6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_lvl_i,
  input  logic                 sck_lvl_i,
  input  logic                 sd_lvl_i,
  output logic                 commit_o,
  output logic [DATA_USED-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);

  logic                 ce_prev_q, sck_prev_q;
  logic [FRAME_LEN-1:0] shr_q;
  logic [CNT_W-1:0]     cnt_q;

  // named internal events
  logic ce_rise, ce_fall, sck_rise, shift_en, len_ok, addr_ok;
  assign ce_rise  = ce_lvl_i & ~ce_prev_q;
  assign ce_fall  = ~ce_lvl_i & ce_prev_q;
  assign sck_rise = sck_lvl_i & ~sck_prev_q;
  assign shift_en = sck_rise & ce_lvl_i & ~ce_rise;
  assign len_ok   = (cnt_q == CNT_FULL);
  assign addr_ok  = (shr_q[ADDR_W-1:0] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      shr_q      <= '0;
      cnt_q      <= '0;
    end else begin
      ce_prev_q  <= ce_lvl_i;
      sck_prev_q <= sck_lvl_i;
      if (ce_rise) begin
        shr_q <= '0;
        cnt_q <= '0;
      end else if (shift_en) begin
        shr_q <= {sd_lvl_i, shr_q[FRAME_LEN-1:1]};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign commit_o = ce_fall & len_ok & addr_ok;
  assign word_o   = shr_q[ADDR_W +: DATA_USED];

  assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> (cnt_q == '0));
  assert_no_shift_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_lvl_i |=> $stable(shr_q));
endmodule

// File: rtl/eq_cmd_decode.sv
module eq_cmd_decode
  import eq_ctrl_pkg::*;
(
  input  logic [DATA_USED-1:0] word_i,
  output eq_cmd_t              cmd_o
);
  logic [FREQ_W-1:0] f_code;
  logic [GAIN_W-1:0] g_code;

  assign f_code = word_i[POS_FREQ +: FREQ_W];
  assign g_code = word_i[POS_GAIN +: GAIN_W];

  always_comb begin
    cmd_o         = '0;
    cmd_o.ch_mask = word_i[POS_CH +: NUM_CH];
    cmd_o.band    = band_lookup(word_i[POS_BAND +: BAND_W]);
    cmd_o.freq    = f_code;
    cmd_o.freq_en = freq_ok(f_code);
    cmd_o.gain    = g_code;
    cmd_o.gain_en = gain_ok(g_code);
    cmd_o.q       = word_i[POS_Q +: Q_W];
    cmd_o.dbl     = word_i[POS_DBL];
  end
endmodule

// File: rtl/eq_reg_bank.sv
module eq_reg_bank
  import eq_ctrl_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               commit_i,
  input  eq_cmd_t                            cmd_i,
  output logic [NUM_BANDS-1:0][FREQ_W-1:0]   freq_o [NUM_CH],
  output logic [NUM_BANDS-1:0][GAIN_W-1:0]   gain_o [NUM_CH],
  output logic [NUM_BANDS-1:0][Q_W-1:0]      q_o    [NUM_CH],
  output logic [NUM_CH-1:0]                  shelf_o,
  output logic                               dbl_o
);
  localparam int CH_BITS   = NUM_BANDS * (FREQ_W + GAIN_W + Q_W);
  localparam int FLAT_W    = NUM_CH * CH_BITS + NUM_CH + 1;

  logic [NUM_CH-1:0][NUM_BANDS-1:0] wr_band;
  logic [NUM_CH-1:0]                wr_shelf;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      wr_shelf[c] = commit_i & cmd_i.ch_mask[c] & cmd_i.band.shelf_wr;
      for (int b = 0; b < NUM_BANDS; b++)
        wr_band[c][b] = commit_i & cmd_i.ch_mask[c] & cmd_i.band.hit &
                        (cmd_i.band.idx == BIDX_W'(b));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        for (int b = 0; b < NUM_BANDS; b++) begin
          freq_o[c][b] <= '0;
          gain_o[c][b] <= GAIN_W'(GAIN_ZERO);
          q_o[c][b]    <= '0;
        end
      end
      shelf_o <= '0;
      dbl_o   <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        for (int b = 0; b < NUM_BANDS; b++) begin
          if (wr_band[c][b]) begin
            if (cmd_i.freq_en) freq_o[c][b] <= cmd_i.freq;
            if (cmd_i.gain_en) gain_o[c][b] <= cmd_i.gain;
            q_o[c][b] <= cmd_i.q;
          end
        end
        if (wr_shelf[c]) shelf_o[c] <= cmd_i.band.shelf_val;
      end
      if (commit_i) dbl_o <= cmd_i.dbl;
    end
  end

  logic [FLAT_W-1:0] bank_flat;
  always_comb begin
    bank_flat = '0;
    for (int c = 0; c < NUM_CH; c++)
      bank_flat[c*CH_BITS +: CH_BITS] = {freq_o[c], gain_o[c], q_o[c]};
    bank_flat[NUM_CH*CH_BITS +: NUM_CH] = shelf_o;
    bank_flat[FLAT_W-1] = dbl_o;
  end

  assert_hold_between_frames_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_flat) |-> $past(commit_i));
  assert_dbl_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (dbl_o == $past(cmd_i.dbl)));
  assert_shelf_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shelf_o) |-> $past(commit_i && cmd_i.band.shelf_wr));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
      assert_freq_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_o[c][b] <= FREQ_W'(FREQ_MAX));
      assert_gain_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gain_o[c][b] <= GAIN_W'(GAIN_MAX));
    end
  end
endmodule

// File: rtl/eq_serial_ctrl.sv
module eq_serial_ctrl
  import eq_ctrl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'hA6,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce_i,
  input  logic                          sclk_i,
  input  logic                          sdat_i,
  output logic                          dbl_o,
  output logic                          shelf_l_o,
  output logic                          shelf_r_o,
  output logic [NUM_BANDS*FREQ_W-1:0]   freq_l_o,
  output logic [NUM_BANDS*FREQ_W-1:0]   freq_r_o,
  output logic [NUM_BANDS*GAIN_W-1:0]   gain_l_o,
  output logic [NUM_BANDS*GAIN_W-1:0]   gain_r_o,
  output logic [NUM_BANDS*Q_W-1:0]      q_l_o,
  output logic [NUM_BANDS*Q_W-1:0]      q_r_o
);
  logic [2:0]                        pins_s;
  logic                              commit;
  logic [DATA_USED-1:0]              word;
  eq_cmd_t                           cmd;
  logic [NUM_BANDS-1:0][FREQ_W-1:0]  freq_q [NUM_CH];
  logic [NUM_BANDS-1:0][GAIN_W-1:0]  gain_q [NUM_CH];
  logic [NUM_BANDS-1:0][Q_W-1:0]     q_q    [NUM_CH];
  logic [NUM_CH-1:0]                 shelf_q;

  eq_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sdat_i, sclk_i, ce_i}),
    .dout (pins_s)
  );

  eq_frame_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_lvl_i (pins_s[0]),
    .sck_lvl_i(pins_s[1]),
    .sd_lvl_i (pins_s[2]),
    .commit_o (commit),
    .word_o   (word)
  );

  eq_cmd_decode u_dec (
    .word_i(word),
    .cmd_o (cmd)
  );

  eq_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit_i(commit),
    .cmd_i   (cmd),
    .freq_o  (freq_q),
    .gain_o  (gain_q),
    .q_o     (q_q),
    .shelf_o (shelf_q),
    .dbl_o   (dbl_o)
  );

  assign freq_l_o  = freq_q[0];
  assign freq_r_o  = freq_q[1];
  assign gain_l_o  = gain_q[0];
  assign gain_r_o  = gain_q[1];
  assign q_l_o     = q_q[0];
  assign q_r_o     = q_q[1];
  assign shelf_l_o = shelf_q[0];
  assign shelf_r_o = shelf_q[1];
endmodule

// File: tb/eq_serial_ctrl_tb_top.sv
`timescale 1ns/1ps
module eq_serial_ctrl_tb_top;
  localparam int DEV = 'hA6;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ce, sclk, sdat;
  logic dbl, sh_l, sh_r;
  logic [15:0] fl, fr, gl, gr;
  logic [11:0] ql, qr;

  eq_serial_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdat_i(sdat),
    .dbl_o(dbl), .shelf_l_o(sh_l), .shelf_r_o(sh_r),
    .freq_l_o(fl), .freq_r_o(fr), .gain_l_o(gl), .gain_r_o(gr),
    .q_l_o(ql), .q_r_o(qr)
  );

  int n_run = 0, n_fail = 0;
  string scen = "init";
  bit checking = 0;

  int e_freq [2][4];
  int e_gain [2][4];
  int e_q    [2][4];
  int e_shelf[2];
  int e_dbl;
  int pend_cnt = 0, pend_addr, pend_n, pend_data;

  function automatic int mk(int q, int d, int bc, int ch, int f, int g);
    return q + d*8 + bc*16 + ch*128 + f*512 + g*8192;
  endfunction

  function automatic void model_commit(int addr, int n, int data);
    int q, d, bc, chm, f, g, band, sh;
    if (n != 28 || addr != DEV) return;
    q = data % 8; d = (data / 8) % 2; bc = (data / 16) % 8;
    chm = (data / 128) % 4; f = (data / 512) % 16; g = (data / 8192) % 16;
    e_dbl = d;
    band = -1; sh = -1;
    case (bc)
      1: begin band = 0; sh = 0; end
      6: begin band = 0; sh = 1; end
      2: band = 1;
      3: band = 2;
      5: band = 3;
      default: band = -1;
    endcase
    if (band < 0) return;
    for (int c = 0; c < 2; c++) begin
      if (((chm >> c) & 1) == 1) begin
        if (f <= 10) e_freq[c][band] = f;
        if (g <= 12) e_gain[c][band] = g;
        e_q[c][band] = q;
        if (sh >= 0) e_shelf[c] = sh;
      end
    end
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (%s) %s: actual=%0d expected=%0d", req, scen, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int b = 0; b < 4; b++) begin
      check("R6", $sformatf("freq L%0d", b), int'(fl[b*4 +: 4]), e_freq[0][b]);
      check("R6", $sformatf("freq R%0d", b), int'(fr[b*4 +: 4]), e_freq[1][b]);
      check("R7", $sformatf("gain L%0d", b), int'(gl[b*4 +: 4]), e_gain[0][b]);
      check("R7", $sformatf("gain R%0d", b), int'(gr[b*4 +: 4]), e_gain[1][b]);
      check("R8", $sformatf("q L%0d", b), int'(ql[b*3 +: 3]), e_q[0][b]);
      check("R8", $sformatf("q R%0d", b), int'(qr[b*3 +: 3]), e_q[1][b]);
    end
    check("R5", "shelf L", int'(sh_l), e_shelf[0]);
    check("R5", "shelf R", int'(sh_r), e_shelf[1]);
    check("R9", "double", int'(dbl), e_dbl);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) model_commit(pend_addr, pend_n, pend_data);
    end
    if (checking) compare_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(string tag, int addr, int data, int nclk);
    logic [27:0] frame;
    scen = tag;
    frame = {data[19:0], addr[7:0]};
    ce = 1'b1;
    ticks(4);
    for (int i = 0; i < nclk; i++) begin
      sdat = (i < 28) ? frame[i] : 1'b1;
      sclk = 1'b0;
      ticks(3);
      sclk = 1'b1;
      ticks(3);
    end
    sclk = 1'b0;
    ticks(3);
    ce = 1'b0;
    pend_addr = addr; pend_n = nclk; pend_data = data; pend_cnt = LAT;
    ticks(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 4; b++) begin
        e_freq[c][b] = 0; e_gain[c][b] = 6; e_q[c][b] = 0;
      end
      e_shelf[c] = 0;
    end
    e_dbl = 0;
    rst_n = 1'b0; ce = 1'b0; sclk = 1'b0; sdat = 1'b0;
    ticks(3);
    rst_n = 1'b1;
    checking = 1;
    scen = "R10 reset state";
    ticks(4);

    // stray serial clocks with enable low must not shift (R1)
    scen = "R1 clocks while idle";
    for (int i = 0; i < 5; i++) begin
      sdat = 1'b1; sclk = 1'b1; ticks(3); sclk = 1'b0; ticks(3);
    end

    send("R1 R4 left low-mid",           DEV, mk(3, 0, 2, 1, 5, 9), 28);
    send("R4 R6 R7 R8 right high edges", DEV, mk(7, 0, 5, 2, 10, 12), 28);
    send("R4 R5 both low shelving",      DEV, mk(0, 0, 6, 3, 0, 0), 28);
    send("R5 left low peaking",          DEV, mk(5, 0, 1, 1, 2, 4), 28);
    send("R6 freq 11 ignored",           DEV, mk(2, 0, 3, 3, 11, 8), 28);
    send("R7 gain 13 ignored",           DEV, mk(6, 0, 3, 1, 7, 13), 28);
    send("R6 R7 freq 15 gain 15",        DEV, mk(1, 0, 2, 2, 15, 15), 28);
    send("R3 wrong address",             DEV ^ 1, mk(4, 1, 5, 3, 3, 3), 28);
    send("R3 address high bit",          DEV ^ 'h80, mk(4, 1, 5, 3, 3, 3), 28);
    send("R2 27 clocks",                 DEV, mk(4, 1, 5, 3, 3, 3), 27);
    send("R2 29 clocks",                 DEV, mk(4, 1, 5, 3, 3, 3), 29);
    send("R2 restart after short frame", DEV, mk(4, 0, 5, 3, 3, 3), 28);
    send("R9 doubling only code 000",    DEV, mk(7, 1, 0, 3, 9, 11), 28);
    send("R9 doubling only code 100",    DEV, mk(6, 1, 4, 3, 1, 2), 28);
    send("R9 clear doubling with band",  DEV, mk(2, 0, 3, 2, 4, 10), 28);
    send("R9 doubling plus band data",   DEV, mk(5, 1, 5, 1, 8, 1), 28);
    send("R4 no channel selected",       DEV, mk(3, 0, 2, 0, 9, 0), 28);
    send("R5 reserved band code 111",    DEV, mk(3, 0, 7, 3, 9, 0), 28);
    send("R5 right shelving only",       DEV, mk(4, 0, 6, 2, 6, 12), 28);
    send("R8 all q on left high",        DEV, mk(0, 0, 5, 1, 10, 0), 28);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule